// File: doc/BRIEF.md
# ISDN Terminal Layer-1 Activation Controller

This block is the state machine that sits on the terminal side of an ISDN basic-rate S/T line. It controls activation and deactivation of layer 1. A microprocessor writes 4-bit command codes with a one-cycle write strobe. The block answers with a 4-bit indication code and a one-cycle strobe each time that code changes. On the line side it takes already-decoded receive flags: INFO 0 present, INFO 2 present, INFO 4 present, signal level present and frame sync. It produces a selector that tells the transmitter which INFO signal to send.

The controller also does four other things:
- It gates the internal clock enable.
- It switches the line-awake detector on and off.
- It exports the D-channel priority class chosen by the latest activate command.
- It runs three test modes: isolated alternating pulses, continuous alternating pulses and analog loopback. The pulse timing comes from a 192 kHz reference tick input.

Line coding, framing, the analog front end and D-channel arbitration are outside the block.

A layer-1 reset command parks the block in a dead state. In that state it sends INFO 0, ignores the line, reports nothing and listens only for the enable-clock command.

Top module: `te_l1_activation`

## Requirements
- R1: After hardware reset the block is in the layer-1 reset state with the following outputs: `ind_code` = 4'b1111, `ind_valid` = 0, `tx_sel` = 2'b00 (INFO 0), `clk_en` = 0, `det_en` = 0, `loop_en` = 0 and no pulses. Reset release passes through a two-stage synchronizer.
- R2: Command codes are: enable clock 4'b0000, layer-1 reset 4'b0001, single pulses 4'b0010, continuous pulses 4'b0100, activate with priority 8 4'b1000, activate with priority 10 4'b1001, analog loopback 4'b1010 and deactivate 4'b1111. In the reset state the only command that acts is enable clock; all others are ignored. Line activity is also ignored there (`det_en` = 0). No indication strobe is produced while in reset.
- R3: Enable clock in the reset or clock-off state moves the block to deactivated-with-clock (F3). F3 reports 4'b0111, with `tx_sel` = 2'b00, `clk_en` = 1 and `det_en` = 1.
- R4: An activate command in F3 moves the block to awaiting-signal (F4), with `tx_sel` = 2'b01 (INFO 1). `d_prio` becomes 0 for priority 8 and 1 for priority 10. An activate command in F4 to F8 only updates `d_prio`.
- R5: In F3 or F4, a level without INFO 0 moves the block to identifying-input (F5). F5 reports 4'b0100 with `tx_sel` = 2'b00.
- R6: INFO 2 with sync in F4, F5, F7 or F8 moves the block to F6. F6 reports 4'b1000 with `tx_sel` = 2'b11 (INFO 3).
- R7: INFO 4 with sync in F4, F5, F6 or F8 moves the block to activated (F7), with `tx_sel` = 2'b11. F7 reports 4'b1100 when `d_prio` = 0 and 4'b1101 when `d_prio` = 1.
- R8: Loss of sync in F6 or F7 moves the block to lost-framing (F8). F8 reports 4'b0100 with `tx_sel` = 2'b00.
- R9: INFO 0 received in F5 to F8 returns the block to F3 and reports 4'b0000. That report holds until the next valid command, which turns it into 4'b0111.
- R10: Deactivate (outside reset) moves the block to clock-off, reporting 4'b1111 with `clk_en` = 0. In clock-off, a level without INFO 0 wakes the block to F5.
- R11: Layer-1 reset from any state enters the reset state with `tx_sel` = 2'b00, `det_en` = 0 and `clk_en` = 0. `ind_code` keeps its last value and is not strobed.
- R12: The single-pulse, continuous-pulse and loopback commands in F3 enter the test state, where they may be changed among themselves. The test state reports 4'b1010, or 4'b1011 while a level is detected, with `tx_sel` = 2'b10. `loop_en` = 1 only in loopback. Enable clock returns the block to F3.
- R13: Each pulse is a one-cycle `pulse_p` or `pulse_n`, one clock after its `ref_tick`. Polarity alternates and starts positive each time the mode is entered. Continuous mode pulses on every tick. Single mode pulses on the first tick and every 96th tick after it. Loopback produces no pulses.
- R14: `ind_valid` is high for exactly the cycles in which `ind_code` takes a new value, and in no other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | One-cycle command write strobe |
| cmd_code | input | 4 | Command code |
| rx_info0 | input | 1 | INFO 0 (no signal) received |
| rx_info2 | input | 1 | INFO 2 received |
| rx_info4 | input | 1 | INFO 4 received |
| rx_level | input | 1 | Signal level detected |
| rx_sync | input | 1 | Receiver frame-synchronized |
| ref_tick | input | 1 | 192 kHz reference tick, one cycle wide |
| ind_code | output | 4 | Current indication code |
| ind_valid | output | 1 | Pulses when ind_code changes |
| tx_sel | output | 2 | Transmit select: 00 INFO 0, 01 INFO 1, 11 INFO 3, 10 test |
| clk_en | output | 1 | Internal clock enable |
| det_en | output | 1 | Line-awake detector enable |
| loop_en | output | 1 | Analog loopback enable |
| d_prio | output | 1 | D-channel priority class: 0 = 8, 1 = 10 |
| pulse_p | output | 1 | Positive test pulse |
| pulse_n | output | 1 | Negative test pulse |

## Verification
A wrong state register shows up on `tx_sel`, `clk_en` and `det_en` at the clock edge that took it, because these outputs decode the state directly. The indication register, which is loaded from the next state, shows the same fault at that same edge. A stale priority bit or a lost network-deactivation flag appears only in the indication code. The bench therefore checks each expected code against the strobe that delivers it and rejects any unexpected strobe. A wrong tick counter or polarity bit shows up on the first pulse, one cycle after the tick that should have produced it, or at the 97th tick in single mode.

// File: rtl/te_l1_pkg.sv
package te_l1_pkg;

  localparam logic [3:0] CMD_CLK_ON       = 4'b0000;
  localparam logic [3:0] CMD_L1_RESET     = 4'b0001;
  localparam logic [3:0] CMD_PULSE_SINGLE = 4'b0010;
  localparam logic [3:0] CMD_PULSE_CONT   = 4'b0100;
  localparam logic [3:0] CMD_ACT_P8       = 4'b1000;
  localparam logic [3:0] CMD_ACT_P10      = 4'b1001;
  localparam logic [3:0] CMD_LOOPBACK     = 4'b1010;
  localparam logic [3:0] CMD_DEACT        = 4'b1111;

  localparam logic [3:0] IND_NET_DEACT    = 4'b0000;
  localparam logic [3:0] IND_LEVEL        = 4'b0100;
  localparam logic [3:0] IND_CLK_ON       = 4'b0111;
  localparam logic [3:0] IND_INFO2        = 4'b1000;
  localparam logic [3:0] IND_TEST         = 4'b1010;
  localparam logic [3:0] IND_TEST_AWAKE   = 4'b1011;
  localparam logic [3:0] IND_ACT_P8       = 4'b1100;
  localparam logic [3:0] IND_ACT_P10      = 4'b1101;
  localparam logic [3:0] IND_CLK_OFF      = 4'b1111;

  typedef enum logic [3:0] {
    ST_RESET, ST_CLK_OFF, ST_IDLE, ST_AWAIT, ST_IDENT,
    ST_SYNC, ST_ACTIVE, ST_LOST, ST_TEST
  } l1_state_e;

  typedef enum logic [1:0] {
    TX_INFO0 = 2'b00, TX_INFO1 = 2'b01, TX_TEST = 2'b10, TX_INFO3 = 2'b11
  } tx_sel_e;

  typedef enum logic [1:0] {
    TM_NONE, TM_SINGLE, TM_CONT, TM_LOOP
  } test_mode_e;

  typedef struct packed {
    logic clk_on;
    logic l1_reset;
    logic single;
    logic cont;
    logic act8;
    logic act10;
    logic loopb;
    logic deact;
  } cmd_dec_t;

  typedef struct packed {
    logic info0;
    logic info2;
    logic info4;
    logic level;
    logic sync;
  } rx_flags_t;

endpackage

// File: rtl/te_rst_sync.sv
module te_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = chain_q[STAGES-1];
endmodule

// File: rtl/te_cmd_decode.sv
module te_cmd_decode
  import te_l1_pkg::*;
(
  input  logic       wr,
  input  logic [3:0] code,
  output cmd_dec_t   dec
);
  always_comb begin
    dec = '0;
    if (wr) begin
      unique case (code)
        CMD_CLK_ON:       dec.clk_on   = 1'b1;
        CMD_L1_RESET:     dec.l1_reset = 1'b1;
        CMD_PULSE_SINGLE: dec.single   = 1'b1;
        CMD_PULSE_CONT:   dec.cont     = 1'b1;
        CMD_ACT_P8:       dec.act8     = 1'b1;
        CMD_ACT_P10:      dec.act10    = 1'b1;
        CMD_LOOPBACK:     dec.loopb    = 1'b1;
        CMD_DEACT:        dec.deact    = 1'b1;
        default:          dec          = '0;
      endcase
    end
  end
endmodule

// File: rtl/te_act_fsm.sv
module te_act_fsm
  import te_l1_pkg::*;
(
  input  logic       clk,
  input  logic       rst_sn,
  input  cmd_dec_t   cmd,
  input  rx_flags_t  rx,
  output l1_state_e  st_q,
  output l1_state_e  st_d,
  output logic       prio_q,
  output logic       prio_d,
  output logic       drd_d,
  output test_mode_e tm_q
);
  logic       drd_q;
  test_mode_e tm_d;
  logic       any_cmd;
  logic       any_act;
  logic       line_wake;

  always_comb begin
    any_cmd   = |cmd;
    any_act   = cmd.act8 | cmd.act10;
    line_wake = rx.level & ~rx.info0;
  end

  always_comb begin
    st_d   = st_q;
    prio_d = prio_q;
    drd_d  = drd_q & ~any_cmd;
    tm_d   = tm_q;
    if (cmd.l1_reset) begin
      st_d = ST_RESET;
      tm_d = TM_NONE;
    end else if (st_q == ST_RESET) begin
      if (cmd.clk_on) st_d = ST_IDLE;
    end else if (cmd.deact) begin
      st_d = ST_CLK_OFF;
      tm_d = TM_NONE;
    end else begin
      if (any_act && (st_q inside {ST_AWAIT, ST_IDENT, ST_SYNC, ST_ACTIVE, ST_LOST}))
        prio_d = cmd.act10;
      unique case (st_q)
        ST_CLK_OFF: begin
          if (cmd.clk_on) st_d = ST_IDLE;
          else if (any_act) begin
            st_d   = ST_AWAIT;
            prio_d = cmd.act10;
          end else if (line_wake) st_d = ST_IDENT;
        end
        ST_IDLE: begin
          if (any_act) begin
            st_d   = ST_AWAIT;
            prio_d = cmd.act10;
          end else if (cmd.single) begin
            st_d = ST_TEST;
            tm_d = TM_SINGLE;
          end else if (cmd.cont) begin
            st_d = ST_TEST;
            tm_d = TM_CONT;
          end else if (cmd.loopb) begin
            st_d = ST_TEST;
            tm_d = TM_LOOP;
          end else if (line_wake) st_d = ST_IDENT;
        end
        ST_TEST: begin
          if (cmd.clk_on) begin
            st_d = ST_IDLE;
            tm_d = TM_NONE;
          end else if (cmd.single) tm_d = TM_SINGLE;
          else if (cmd.cont)       tm_d = TM_CONT;
          else if (cmd.loopb)      tm_d = TM_LOOP;
        end
        ST_AWAIT: begin
          if (!rx.info0) begin
            if (rx.sync && rx.info4)      st_d = ST_ACTIVE;
            else if (rx.sync && rx.info2) st_d = ST_SYNC;
            else if (rx.level)            st_d = ST_IDENT;
          end
        end
        ST_IDENT, ST_LOST: begin
          if (rx.info0) begin
            st_d  = ST_IDLE;
            drd_d = 1'b1;
          end else if (rx.sync && rx.info4) st_d = ST_ACTIVE;
          else if (rx.sync && rx.info2)     st_d = ST_SYNC;
        end
        ST_SYNC: begin
          if (rx.info0) begin
            st_d  = ST_IDLE;
            drd_d = 1'b1;
          end else if (!rx.sync) st_d = ST_LOST;
          else if (rx.info4)     st_d = ST_ACTIVE;
        end
        ST_ACTIVE: begin
          if (rx.info0) begin
            st_d  = ST_IDLE;
            drd_d = 1'b1;
          end else if (!rx.sync) st_d = ST_LOST;
          else if (rx.info2)     st_d = ST_SYNC;
        end
        default: st_d = st_q;
      endcase
    end
    if (st_d != ST_IDLE) drd_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q   <= ST_RESET;
      prio_q <= 1'b0;
      drd_q  <= 1'b0;
      tm_q   <= TM_NONE;
    end else begin
      st_q   <= st_d;
      prio_q <= prio_d;
      drd_q  <= drd_d;
      tm_q   <= tm_d;
    end
  end

  // R2: reset state is left only through the enable-clock command
  a_r2_reset_sticky: assert property (@(posedge clk) disable iff (!rst_sn)
    (st_q == ST_RESET && !cmd.clk_on) |=> (st_q == ST_RESET));

  // R11: layer-1 reset command always lands in the reset state
  a_r11_reset_cmd: assert property (@(posedge clk) disable iff (!rst_sn)
    cmd.l1_reset |=> (st_q == ST_RESET));

  // R10: deactivate outside reset always reaches clock-off
  a_r10_deact: assert property (@(posedge clk) disable iff (!rst_sn)
    (cmd.deact && st_q != ST_RESET) |=> (st_q == ST_CLK_OFF));

  // R12: a test mode is only held inside the test state
  a_r12_mode_in_test: assert property (@(posedge clk) disable iff (!rst_sn)
    (tm_q != TM_NONE) |-> (st_q == ST_TEST));
endmodule

// File: rtl/te_ind_gen.sv
module te_ind_gen
  import te_l1_pkg::*;
(
  input  logic       clk,
  input  logic       rst_sn,
  input  l1_state_e  st_d,
  input  logic       prio_d,
  input  logic       drd_d,
  input  logic       rx_level,
  output logic [3:0] ind_code,
  output logic       ind_valid
);
  logic [3:0] ind_q;
  logic [3:0] ind_want;
  logic       ind_load;

  always_comb begin
    unique case (st_d)
      ST_CLK_OFF:        ind_want = IND_CLK_OFF;
      ST_IDLE:           ind_want = drd_d ? IND_NET_DEACT : IND_CLK_ON;
      ST_AWAIT:          ind_want = IND_CLK_ON;
      ST_IDENT, ST_LOST: ind_want = IND_LEVEL;
      ST_SYNC:           ind_want = IND_INFO2;
      ST_ACTIVE:         ind_want = prio_d ? IND_ACT_P10 : IND_ACT_P8;
      ST_TEST:           ind_want = rx_level ? IND_TEST_AWAKE : IND_TEST;
      default:           ind_want = ind_q;
    endcase
    ind_load = (st_d != ST_RESET) && (ind_want != ind_q);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ind_q     <= IND_CLK_OFF;
      ind_valid <= 1'b0;
    end else begin
      ind_valid <= ind_load;
      if (ind_load) ind_q <= ind_want;
    end
  end

  assign ind_code = ind_q;

  // R14: a strobe always carries a new code
  a_r14_strobe_new: assert property (@(posedge clk) disable iff (!rst_sn)
    ind_valid |-> (ind_code != $past(ind_code)));

  // R14: a code change is always strobed
  a_r14_change_strobed: assert property (@(posedge clk) disable iff (!rst_sn)
    (ind_code != $past(ind_code)) |-> ind_valid);

  // R2: nothing is reported while heading into reset
  a_r2_quiet_reset: assert property (@(posedge clk) disable iff (!rst_sn)
    (st_d == ST_RESET) |=> !ind_valid);
endmodule

// File: rtl/te_pulse_gen.sv
module te_pulse_gen
  import te_l1_pkg::*;
#(
  parameter int SINGLE_TICKS = 96
) (
  input  logic       clk,
  input  logic       rst_sn,
  input  test_mode_e tm,
  input  logic       ref_tick,
  output logic       pulse_p,
  output logic       pulse_n
);
  localparam int CW = $clog2(SINGLE_TICKS);
  localparam logic [CW-1:0] LAST = CW'(SINGLE_TICKS - 1);

  test_mode_e    mode_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pol_q, pol_d;
  logic          p_d, n_d;
  logic          fire;
  logic          restart;

  always_comb begin
    restart = (tm != mode_q);
    fire    = ref_tick && ((mode_q == TM_CONT) ||
                           (mode_q == TM_SINGLE && cnt_q == '0));
    cnt_d   = cnt_q;
    pol_d   = pol_q;
    p_d     = 1'b0;
    n_d     = 1'b0;
    if (restart) begin
      cnt_d = '0;
      pol_d = 1'b0;
    end else begin
      p_d = fire & ~pol_q;
      n_d = fire & pol_q;
      if (fire) pol_d = ~pol_q;
      if (ref_tick && mode_q == TM_SINGLE)
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      mode_q  <= TM_NONE;
      cnt_q   <= '0;
      pol_q   <= 1'b0;
      pulse_p <= 1'b0;
      pulse_n <= 1'b0;
    end else begin
      mode_q  <= tm;
      cnt_q   <= cnt_d;
      pol_q   <= pol_d;
      pulse_p <= p_d;
      pulse_n <= n_d;
    end
  end

  // R13: never both polarities at once
  a_r13_one_polarity: assert property (@(posedge clk) disable iff (!rst_sn)
    !(pulse_p && pulse_n));

  // R13: no pulse outside the two pulse modes
  a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_sn)
    (mode_q != TM_SINGLE && mode_q != TM_CONT) |=> !(pulse_p || pulse_n));

  // R13: a pulse follows a tick
  a_r13_after_tick: assert property (@(posedge clk) disable iff (!rst_sn)
    (pulse_p || pulse_n) |-> $past(ref_tick));
endmodule

// File: rtl/te_l1_activation.sv
module te_l1_activation
  import te_l1_pkg::*;
#(
  parameter int SINGLE_TICKS = 96,
  parameter int RST_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [3:0] cmd_code,
  input  logic       rx_info0,
  input  logic       rx_info2,
  input  logic       rx_info4,
  input  logic       rx_level,
  input  logic       rx_sync,
  input  logic       ref_tick,
  output logic [3:0] ind_code,
  output logic       ind_valid,
  output logic [1:0] tx_sel,
  output logic       clk_en,
  output logic       det_en,
  output logic       loop_en,
  output logic       d_prio,
  output logic       pulse_p,
  output logic       pulse_n
);
  logic       rst_sn;
  cmd_dec_t   cmd;
  rx_flags_t  rx;
  l1_state_e  st_q, st_d;
  logic       prio_q, prio_d, drd_d;
  test_mode_e tm_q;
  tx_sel_e    tx_e;

  assign rx = '{info0: rx_info0, info2: rx_info2, info4: rx_info4,
                level: rx_level, sync: rx_sync};

  te_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  te_cmd_decode u_dec (.wr(cmd_wr), .code(cmd_code), .dec(cmd));

  te_act_fsm u_fsm (
    .clk(clk), .rst_sn(rst_sn), .cmd(cmd), .rx(rx),
    .st_q(st_q), .st_d(st_d), .prio_q(prio_q), .prio_d(prio_d),
    .drd_d(drd_d), .tm_q(tm_q));

  te_ind_gen u_ind (
    .clk(clk), .rst_sn(rst_sn), .st_d(st_d), .prio_d(prio_d),
    .drd_d(drd_d), .rx_level(rx_level),
    .ind_code(ind_code), .ind_valid(ind_valid));

  te_pulse_gen #(.SINGLE_TICKS(SINGLE_TICKS)) u_pulse (
    .clk(clk), .rst_sn(rst_sn), .tm(tm_q), .ref_tick(ref_tick),
    .pulse_p(pulse_p), .pulse_n(pulse_n));

  always_comb begin
    unique case (st_q)
      ST_AWAIT:           tx_e = TX_INFO1;
      ST_SYNC, ST_ACTIVE: tx_e = TX_INFO3;
      ST_TEST:            tx_e = TX_TEST;
      default:            tx_e = TX_INFO0;
    endcase
    tx_sel  = tx_e;
    clk_en  = (st_q != ST_RESET) && (st_q != ST_CLK_OFF);
    det_en  = (st_q != ST_RESET);
    loop_en = (st_q == ST_TEST) && (tm_q == TM_LOOP);
    d_prio  = prio_q;
  end

  // R11: reset state never transmits anything but INFO 0 at the port
  a_r11_reset_tx: assert property (@(posedge clk) disable iff (!rst_sn)
    $past(cmd.l1_reset) |-> (tx_sel == 2'b00 && !det_en));
endmodule

// File: tb/te_l1_activation_tb.sv
module te_l1_activation_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_wr;
  logic [3:0] cmd_code;
  logic       rx_info0, rx_info2, rx_info4, rx_level, rx_sync, ref_tick;
  logic [3:0] ind_code;
  logic       ind_valid;
  logic [1:0] tx_sel;
  logic       clk_en, det_en, loop_en, d_prio, pulse_p, pulse_n;

  int checks = 0;
  int errs   = 0;
  logic [3:0] exp_q[$];
  string      req_q[$];
  logic [3:0] e_code;
  string      e_req;

  always #4 clk = ~clk;

  te_l1_activation dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
    .rx_info0(rx_info0), .rx_info2(rx_info2), .rx_info4(rx_info4),
    .rx_level(rx_level), .rx_sync(rx_sync), .ref_tick(ref_tick),
    .ind_code(ind_code), .ind_valid(ind_valid), .tx_sel(tx_sel),
    .clk_en(clk_en), .det_en(det_en), .loop_en(loop_en), .d_prio(d_prio),
    .pulse_p(pulse_p), .pulse_n(pulse_n));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic expect_ind(input logic [3:0] c, input string req);
    exp_q.push_back(c);
    req_q.push_back(req);
  endtask

  task automatic wr_cmd(input logic [3:0] c);
    @(negedge clk);
    cmd_code = c;
    cmd_wr   = 1'b1;
    @(negedge clk);
    cmd_wr   = 1'b0;
  endtask

  task automatic set_rx(input logic i0, input logic i2, input logic i4,
                        input logic lv, input logic sy);
    @(negedge clk);
    rx_info0 = i0; rx_info2 = i2; rx_info4 = i4; rx_level = lv; rx_sync = sy;
    @(negedge clk);
  endtask

  task automatic tick(output logic p, output logic n);
    @(negedge clk);
    ref_tick = 1'b1;
    @(negedge clk);
    ref_tick = 1'b0;
    p = pulse_p;
    n = pulse_n;
  endtask

  // monitor: pops expected indications as strobes arrive
  always @(negedge clk) begin
    if (rst_n && ind_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errs++;
        $display("FAIL R14 unexpected strobe: actual=%b expected=none", ind_code);
      end else begin
        e_code = exp_q.pop_front();
        e_req  = req_q.pop_front();
        if (ind_code != e_code) begin
          errs++;
          $display("FAIL %s indication: actual=%b expected=%b", e_req, ind_code, e_code);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog expired: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic p, n;
    int   stray;
    rst_n = 1'b0; cmd_wr = 1'b0; cmd_code = 4'b0000; ref_tick = 1'b0;
    rx_info0 = 1'b1; rx_info2 = 1'b0; rx_info4 = 1'b0; rx_level = 1'b0; rx_sync = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1", "ind_code", ind_code, 4'b1111);
    chk("R1", "ind_valid", ind_valid, 0);
    chk("R1", "tx_sel", tx_sel, 2'b00);
    chk("R1", "clk_en", clk_en, 0);
    chk("R1", "det_en", det_en, 0);

    // R2 reset ignores line and non-enable commands
    set_rx(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    chk("R2", "clk_en after line level", clk_en, 0);
    wr_cmd(4'b1000);
    chk("R2", "tx_sel after activate", tx_sel, 2'b00);
    wr_cmd(4'b1111);
    chk("R2", "clk_en after deactivate", clk_en, 0);
    set_rx(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);

    // R3 enable clock
    expect_ind(4'b0111, "R3");
    wr_cmd(4'b0000);
    chk("R3", "clk_en", clk_en, 1);
    chk("R3", "det_en", det_en, 1);
    chk("R3", "tx_sel", tx_sel, 2'b00);

    // R4 activate with priority 10
    wr_cmd(4'b1001);
    chk("R4", "tx_sel INFO1", tx_sel, 2'b01);
    chk("R4", "d_prio", d_prio, 1);
    chk("R4", "ind_code held", ind_code, 4'b0111);

    // R5 level without INFO0
    expect_ind(4'b0100, "R5");
    set_rx(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R5", "tx_sel", tx_sel, 2'b00);

    // R6 INFO2 with sync
    expect_ind(4'b1000, "R6");
    set_rx(1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R6", "tx_sel INFO3", tx_sel, 2'b11);

    // R7 INFO4 at priority 10, then re-prioritise to 8
    expect_ind(4'b1101, "R7");
    set_rx(1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    chk("R7", "tx_sel INFO3", tx_sel, 2'b11);
    expect_ind(4'b1100, "R7");
    wr_cmd(4'b1000);
    chk("R4", "d_prio after priority 8", d_prio, 0);

    // R8 loss of sync
    expect_ind(4'b0100, "R8");
    set_rx(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R8", "tx_sel", tx_sel, 2'b00);
    expect_ind(4'b1100, "R7");
    set_rx(1'b0, 1'b0, 1'b1, 1'b1, 1'b1);

    // R9 INFO0 from network
    expect_ind(4'b0000, "R9");
    set_rx(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R9", "tx_sel", tx_sel, 2'b00);
    chk("R9", "clk_en", clk_en, 1);
    expect_ind(4'b0111, "R9");
    wr_cmd(4'b0000);

    // R12/R13 continuous pulses
    expect_ind(4'b1010, "R12");
    wr_cmd(4'b0100);
    @(negedge clk);
    chk("R12", "tx_sel test", tx_sel, 2'b10);
    chk("R12", "loop_en", loop_en, 0);
    for (int i = 0; i < 4; i++) begin
      tick(p, n);
      chk("R13", "cont pulse_p", p, (i % 2 == 0) ? 1 : 0);
      chk("R13", "cont pulse_n", n, (i % 2 == 1) ? 1 : 0);
    end

    // R12 awake test indication
    expect_ind(4'b1011, "R12");
    set_rx(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    expect_ind(4'b1010, "R12");
    set_rx(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);

    // R13 single pulses
    wr_cmd(4'b0010);
    @(negedge clk);
    stray = 0;
    for (int i = 1; i <= 97; i++) begin
      tick(p, n);
      if (i == 1) begin
        chk("R13", "single first pulse_p", p, 1);
        chk("R13", "single first pulse_n", n, 0);
      end else if (i == 97) begin
        chk("R13", "single second pulse_p", p, 0);
        chk("R13", "single second pulse_n", n, 1);
      end else if (p || n) stray++;
    end
    chk("R13", "single stray pulses", stray, 0);

    // R12 loopback
    wr_cmd(4'b1010);
    @(negedge clk);
    chk("R12", "loop_en", loop_en, 1);
    tick(p, n);
    chk("R13", "loopback no pulse", p || n, 0);

    // R12 exit test
    expect_ind(4'b0111, "R12");
    wr_cmd(4'b0000);
    chk("R12", "loop_en after exit", loop_en, 0);

    // R10 deactivate and wake
    expect_ind(4'b1111, "R10");
    wr_cmd(4'b1111);
    chk("R10", "clk_en", clk_en, 0);
    expect_ind(4'b0100, "R10");
    set_rx(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R10", "clk_en after wake", clk_en, 1);

    // R11 layer-1 reset
    wr_cmd(4'b0001);
    chk("R11", "tx_sel", tx_sel, 2'b00);
    chk("R11", "det_en", det_en, 0);
    chk("R11", "clk_en", clk_en, 0);
    chk("R11", "ind_code held", ind_code, 4'b0100);
    set_rx(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_ind(4'b0111, "R3");
    wr_cmd(4'b0000);
    repeat (3) @(negedge clk);

    chk("R14", "pending expected strobes", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule